// File: doc/BRIEF.md
# Scoreboard Dynamic Issue Controller

This block schedules an in-order instruction stream onto a small group of functional units and lets them start and finish out of order. Each arriving instruction names an operation class, a destination register and two source registers. The controller keeps a status entry for each functional unit and a table that maps each register to the unit that will produce it. From these two tables it decides when an instruction may enter a unit, when that unit may read its operands, and when it may write its result. Each decision checks for one kind of hazard: write-after-write, read-after-write and write-after-read.

Five units are built: one integer/load unit (index 0), two multipliers (indices 1 and 2), an adder (index 3) and a divider (index 4). Execution is modelled by a latency counter per unit. No arithmetic is done. The outputs are an issue-stall flag, a start pulse for each unit carrying the register numbers it read, a write-result grant for each unit with the register written, and a debug view of where each unit's instruction stands.

Top module: `sb_issue_ctrl`

## Requirements
- R1: Operation class codes are 0 integer/load (unit 0), 1 multiply (units 1 and 2), 2 add (unit 3) and 3 divide (unit 4). An offered instruction is accepted at a clock edge only if a unit of its class is idle. Otherwise `issue_stall` is high in the same cycle.
- R2: An offered instruction also stalls while its destination register is owned by an active instruction. It issues at the first edge after that owner has written its result.
- R3: At most one instruction issues per edge. A stalled instruction stays at the input, and no later instruction is accepted ahead of it.
- R4: A unit reads its operands at the first edge at which both sources are ready. A source is ready when no earlier active instruction still has to write it. The start pulse `start_vld[u]` appears in the cycle after that edge, with `start_dst`, `start_src1` and `start_src2` holding the unit's registers.
- R5: A unit becomes done exactly L edges after its read edge. L is 1 for integer, 8 for multiply, 2 for add and 6 for divide. It asks to write at the next edge.
- R6: A done unit may not write while another unit still waits to read an operand that names the same register as the result and whose ready flag is set.
- R7: When several units may write at one edge, the lowest unit index wins. At most one bit of `wr_grant` is high in any cycle.
- R8: A multiply instruction takes the lowest-index idle multiplier.
- R9: At a write edge the unit becomes idle and its register is released. Units waiting on that result see the operand ready, and can read it at the following edge. `wr_grant[u]` and `wr_reg` appear in the cycle after the write edge.
- R10: `dbg_stage` holds 2 bits per unit: 0 idle, 1 waiting for operands, 2 executing, 3 waiting to write. `dbg_tag` holds 4 bits per unit: the issue order number of its instruction, counted from 0 after reset.
- R11: While reset is active and after it, all stages are idle, and no start pulse or write grant is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered |
| in_op | input | 2 | Operation class of the offered instruction |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| issue_stall | output | 1 | Offered instruction cannot issue this cycle |
| start_vld | output | 5 | Per-unit start-execute pulse |
| start_dst | output | 20 | Per-unit destination register at start, 4 bits per unit |
| start_src1 | output | 20 | Per-unit first source at start |
| start_src2 | output | 20 | Per-unit second source at start |
| wr_grant | output | 5 | Per-unit write-result grant pulse |
| wr_reg | output | 4 | Register written by the granted unit |
| dbg_stage | output | 10 | Per-unit stage code |
| dbg_tag | output | 20 | Per-unit instruction order tag |

## Verification
A wrong ready flag or a wrong producer field in a unit's entry shows up as a start pulse one or more cycles earlier or later than the producer's write grant allows. A missing release of the register table shows up as a stall that lasts forever at the next instruction that writes that register. A broken write-after-read check lets a grant appear while a waiting unit's stage is still 1, which is several cycles ahead of the expected edge. A known six-instruction sequence and two short directed sequences therefore pin every issue, start and grant edge, so any such fault is seen within a few cycles of the event it disturbs.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 5;

  typedef enum logic [1:0] {
    OP_INT = 2'd0,
    OP_MUL = 2'd1,
    OP_ADD = 2'd2,
    OP_DIV = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } stage_e;

  // operation class served by each unit index
  function automatic op_e fu_class(input int idx);
    case (idx)
      0:       return OP_INT;
      1, 2:    return OP_MUL;
      3:       return OP_ADD;
      default: return OP_DIV;
    endcase
  endfunction
endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_REGS = 16,
  parameter int QW       = 3,
  parameter int NONE     = 5,
  localparam int RW      = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] rd_a_addr,
  output logic [QW-1:0] rd_a_data,
  input  logic [RW-1:0] rd_b_addr,
  output logic [QW-1:0] rd_b_data,
  input  logic [RW-1:0] rd_c_addr,
  output logic [QW-1:0] rd_c_data,
  input  logic          set_en,
  input  logic [RW-1:0] set_addr,
  input  logic [QW-1:0] set_val,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_addr
);
  logic [QW-1:0] owner [NUM_REGS];

  assign rd_a_data = owner[rd_a_addr];
  assign rd_b_data = owner[rd_b_addr];
  assign rd_c_data = owner[rd_c_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) owner[r] <= QW'(NONE);
    end else begin
      if (clr_en) owner[clr_addr] <= QW'(NONE);
      if (set_en) owner[set_addr] <= set_val;
    end
  end
endmodule

// File: rtl/sb_fu_timer.sv
module sb_fu_timer #(
  parameter int LAT = 4,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= CW'(LAT);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  parameter int LAT_INT  = 1,
  parameter int LAT_MUL  = 8,
  parameter int LAT_ADD  = 2,
  parameter int LAT_DIV  = 6,
  localparam int RW      = $clog2(NUM_REGS),
  localparam int QW      = $clog2(NUM_FU + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [1:0]              in_op,
  input  logic [RW-1:0]           in_dst,
  input  logic [RW-1:0]           in_src1,
  input  logic [RW-1:0]           in_src2,
  output logic                    issue_stall,
  output logic [NUM_FU-1:0]       start_vld,
  output logic [NUM_FU*RW-1:0]    start_dst,
  output logic [NUM_FU*RW-1:0]    start_src1,
  output logic [NUM_FU*RW-1:0]    start_src2,
  output logic [NUM_FU-1:0]       wr_grant,
  output logic [RW-1:0]           wr_reg,
  output logic [NUM_FU*2-1:0]     dbg_stage,
  output logic [NUM_FU*TAG_W-1:0] dbg_tag
);
  localparam logic [QW-1:0] NONE = QW'(NUM_FU);

  // unit status table
  stage_e          stage [NUM_FU];
  logic [RW-1:0]   fi    [NUM_FU];
  logic [RW-1:0]   fj    [NUM_FU];
  logic [RW-1:0]   fk    [NUM_FU];
  logic [QW-1:0]   qj    [NUM_FU];
  logic [QW-1:0]   qk    [NUM_FU];
  logic            rj    [NUM_FU];
  logic            rk    [NUM_FU];
  logic [TAG_W-1:0] tag  [NUM_FU];
  logic [TAG_W-1:0] tag_ctr;

  logic [RW-1:0]   sd  [NUM_FU];
  logic [RW-1:0]   ss1 [NUM_FU];
  logic [RW-1:0]   ss2 [NUM_FU];

  // register result status lookups
  logic [QW-1:0] dst_owner, src1_owner, src2_owner;

  // issue selection
  logic [QW-1:0] cand;
  logic          cand_found;
  logic          issue_ok, issue_fire;

  // per-unit control
  logic [NUM_FU-1:0] read_go, expired, no_war, wr_req, wr_gnt;
  logic [QW-1:0]     wr_idx;
  logic              wr_any;

  sb_reg_status #(
    .NUM_REGS (NUM_REGS),
    .QW       (QW),
    .NONE     (NUM_FU)
  ) u_regstat (
    .clk       (clk),
    .rst       (rst),
    .rd_a_addr (in_dst),
    .rd_a_data (dst_owner),
    .rd_b_addr (in_src1),
    .rd_b_data (src1_owner),
    .rd_c_addr (in_src2),
    .rd_c_data (src2_owner),
    .set_en    (issue_fire),
    .set_addr  (in_dst),
    .set_val   (cand),
    .clr_en    (wr_any),
    .clr_addr  (fi[wr_idx])
  );

  // lowest idle unit of the requested class
  always_comb begin
    cand       = NONE;
    cand_found = 1'b0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (fu_class(i) == op_e'(in_op) && stage[i] == ST_IDLE) begin
        cand       = QW'(i);
        cand_found = 1'b1;
      end
    end
  end

  assign issue_ok    = cand_found && (dst_owner == NONE);
  assign issue_fire  = in_valid && issue_ok;
  assign issue_stall = in_valid && !issue_ok;

  // operand read and write-after-read screening
  always_comb begin
    for (int i = 0; i < NUM_FU; i++) begin
      read_go[i] = (stage[i] == ST_WAIT) && rj[i] && rk[i];
      no_war[i]  = 1'b1;
      for (int j = 0; j < NUM_FU; j++) begin
        if (j != i && stage[j] == ST_WAIT &&
            ((fj[j] == fi[i] && rj[j]) || (fk[j] == fi[i] && rk[j])))
          no_war[i] = 1'b0;
      end
      wr_req[i] = (stage[i] == ST_DONE) && no_war[i];
    end
  end

  sb_wb_arbiter #(
    .N  (NUM_FU),
    .IW (QW)
  ) u_arb (
    .req (wr_req),
    .gnt (wr_gnt),
    .idx (wr_idx),
    .any (wr_any)
  );

  generate
    for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
      localparam int LAT_G = (fu_class(g) == OP_INT) ? LAT_INT :
                             (fu_class(g) == OP_MUL) ? LAT_MUL :
                             (fu_class(g) == OP_ADD) ? LAT_ADD : LAT_DIV;
      sb_fu_timer #(.LAT(LAT_G)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (read_go[g]),
        .expired (expired[g])
      );
      assign dbg_stage[g*2 +: 2]          = stage[g];
      assign dbg_tag[g*TAG_W +: TAG_W]    = tag[g];
      assign start_dst[g*RW +: RW]        = sd[g];
      assign start_src1[g*RW +: RW]       = ss1[g];
      assign start_src2[g*RW +: RW]       = ss2[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_FU; i++) begin
        stage[i] <= ST_IDLE;
        fi[i]    <= '0;
        fj[i]    <= '0;
        fk[i]    <= '0;
        qj[i]    <= NONE;
        qk[i]    <= NONE;
        rj[i]    <= 1'b0;
        rk[i]    <= 1'b0;
        tag[i]   <= '0;
        sd[i]    <= '0;
        ss1[i]   <= '0;
        ss2[i]   <= '0;
      end
      tag_ctr   <= '0;
      start_vld <= '0;
      wr_grant  <= '0;
      wr_reg    <= '0;
    end else begin
      for (int i = 0; i < NUM_FU; i++) begin
        case (stage[i])
          ST_IDLE: begin
            if (issue_fire && cand == QW'(i)) begin
              stage[i] <= ST_WAIT;
              fi[i]    <= in_dst;
              fj[i]    <= in_src1;
              fk[i]    <= in_src2;
              tag[i]   <= tag_ctr;
              if (src1_owner != NONE && !(wr_any && src1_owner == wr_idx)) begin
                qj[i] <= src1_owner;
                rj[i] <= 1'b0;
              end else begin
                qj[i] <= NONE;
                rj[i] <= 1'b1;
              end
              if (src2_owner != NONE && !(wr_any && src2_owner == wr_idx)) begin
                qk[i] <= src2_owner;
                rk[i] <= 1'b0;
              end else begin
                qk[i] <= NONE;
                rk[i] <= 1'b1;
              end
            end
          end
          ST_WAIT: begin
            if (read_go[i]) begin
              stage[i] <= ST_EXEC;
              rj[i]    <= 1'b0;
              rk[i]    <= 1'b0;
            end else begin
              if (wr_any && qj[i] == wr_idx) begin
                rj[i] <= 1'b1;
                qj[i] <= NONE;
              end
              if (wr_any && qk[i] == wr_idx) begin
                rk[i] <= 1'b1;
                qk[i] <= NONE;
              end
            end
          end
          ST_EXEC: if (expired[i]) stage[i] <= ST_DONE;
          default: if (wr_gnt[i])  stage[i] <= ST_IDLE;
        endcase

        start_vld[i] <= read_go[i];
        if (read_go[i]) begin
          sd[i]  <= fi[i];
          ss1[i] <= fj[i];
          ss2[i] <= fk[i];
        end
      end

      if (issue_fire) tag_ctr <= tag_ctr + TAG_W'(1);
      wr_grant <= wr_gnt;
      wr_reg   <= wr_any ? fi[wr_idx] : '0;
    end
  end
endmodule

// File: rtl/sb_issue_ctrl_chk.sv
module sb_issue_ctrl_chk
  import sb_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [1:0]          in_op,
  input logic                issue_stall,
  input logic [NUM_FU-1:0]   start_vld,
  input logic [NUM_FU-1:0]   wr_grant,
  input logic [NUM_FU*2-1:0] dbg_stage
);
  // R1: the single integer unit busy forces a stall for an integer instruction
  assert_int_busy_stalls_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'd0 && dbg_stage[1:0] != 2'd0) |-> issue_stall);

  // R1: the single divider busy forces a stall for a divide instruction
  assert_div_busy_stalls_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'd3 && dbg_stage[9:8] != 2'd0) |-> issue_stall);

  // R7: never more than one write grant
  assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_grant));

  generate
    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
      // R4: a start pulse comes with the unit executing
      assert_start_exec_R4: assert property (@(posedge clk) disable iff (rst)
        start_vld[u] |-> (dbg_stage[u*2 +: 2] == 2'd2));

      // R9: a granted unit is idle when its grant is shown
      assert_grant_frees_R9: assert property (@(posedge clk) disable iff (rst)
        wr_grant[u] |-> (dbg_stage[u*2 +: 2] == 2'd0));

      // R10: a waiting unit either keeps waiting or starts executing
      assert_wait_next_R10: assert property (@(posedge clk) disable iff (rst)
        (dbg_stage[u*2 +: 2] == 2'd1) |=>
          (dbg_stage[u*2 +: 2] == 2'd1 || dbg_stage[u*2 +: 2] == 2'd2));

      // R10: an executing unit never jumps back to idle or waiting
      assert_exec_next_R10: assert property (@(posedge clk) disable iff (rst)
        (dbg_stage[u*2 +: 2] == 2'd2) |=>
          (dbg_stage[u*2 +: 2] == 2'd2 || dbg_stage[u*2 +: 2] == 2'd3));
    end
  endgenerate
endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_op       (in_op),
  .issue_stall (issue_stall),
  .start_vld   (start_vld),
  .wr_grant    (wr_grant),
  .dbg_stage   (dbg_stage)
);

// File: tb/sb_issue_ctrl_tb.sv
module sb_issue_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NFU   = 5;
  localparam int NPROG = 12;
  localparam int EDGES = 40;

  // fields: op[40:39] dst[38:35] s1[34:31] s2[30:27] fu[26:24]
  //         issue edge[23:16] start edge[15:8] write edge[7:0]
  localparam logic [40:0] PROG [NPROG] = '{
    // main sequence: RAW, WAW-free out of order completion, WAR on reg 6
    {2'd0, 4'd6,  4'd12, 4'd12, 3'd0, 8'd0,  8'd1,  8'd3 },
    {2'd0, 4'd2,  4'd13, 4'd13, 3'd0, 8'd4,  8'd5,  8'd7 },
    {2'd1, 4'd0,  4'd2,  4'd4,  3'd1, 8'd5,  8'd8,  8'd17},
    {2'd2, 4'd8,  4'd6,  4'd2,  3'd3, 8'd6,  8'd8,  8'd11},
    {2'd3, 4'd10, 4'd0,  4'd6,  3'd4, 8'd7,  8'd18, 8'd25},
    {2'd2, 4'd6,  4'd8,  4'd2,  3'd3, 8'd12, 8'd13, 8'd19},
    // write collision and second multiplier
    {2'd2, 4'd1,  4'd12, 4'd13, 3'd3, 8'd0,  8'd1,  8'd5 },
    {2'd0, 4'd2,  4'd12, 4'd12, 3'd0, 8'd1,  8'd2,  8'd4 },
    {2'd1, 4'd3,  4'd12, 4'd13, 3'd1, 8'd2,  8'd3,  8'd12},
    {2'd1, 4'd4,  4'd12, 4'd13, 3'd2, 8'd3,  8'd4,  8'd13},
    // same destination back to back
    {2'd1, 4'd5,  4'd12, 4'd13, 3'd1, 8'd0,  8'd1,  8'd10},
    {2'd2, 4'd5,  4'd12, 4'd13, 3'd3, 8'd11, 8'd12, 8'd15}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = '0;
  logic [3:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic        issue_stall;
  logic [4:0]  start_vld, wr_grant;
  logic [19:0] start_dst, start_src1, start_src2, dbg_tag;
  logic [3:0]  wr_reg;
  logic [9:0]  dbg_stage;

  int n_chk = 0;
  int n_bad = 0;
  int got_iss [NPROG];
  int got_st  [NPROG];
  int got_wr  [NPROG];

  sb_issue_ctrl u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .issue_stall(issue_stall), .start_vld(start_vld),
    .start_dst(start_dst), .start_src1(start_src1), .start_src2(start_src2),
    .wr_grant(wr_grant), .wr_reg(wr_reg),
    .dbg_stage(dbg_stage), .dbg_tag(dbg_tag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seg(input int s0, input int n);
    int idx;
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(dbg_stage == '0, "R11 stages idle in reset", int'(dbg_stage), 0);
    chk(start_vld == '0 && wr_grant == '0, "R11 no pulses in reset",
        int'({start_vld, wr_grant}), 0);
    rst = 1'b0;
    idx = 0;
    for (int j = s0; j < s0 + n; j++) begin
      got_iss[j] = -1; got_st[j] = -1; got_wr[j] = -1;
    end
    for (int e = 0; e < EDGES; e++) begin
      if (e > 0) begin
        for (int f = 0; f < NFU; f++) begin
          if (start_vld[f]) begin
            bit hit = 1'b0;
            for (int j = s0; j < s0 + n; j++) begin
              if (!hit && int'(PROG[j][26:24]) == f && got_st[j] < 0 && got_iss[j] >= 0) begin
                hit = 1'b1;
                got_st[j] = e - 1;
                chk(start_dst[f*4 +: 4] == PROG[j][38:35] &&
                    start_src1[f*4 +: 4] == PROG[j][34:31] &&
                    start_src2[f*4 +: 4] == PROG[j][30:27],
                    "R4 start registers", int'(start_dst[f*4 +: 4]), int'(PROG[j][38:35]));
              end
            end
          end
          if (wr_grant[f]) begin
            bit hit = 1'b0;
            for (int j = s0; j < s0 + n; j++) begin
              if (!hit && int'(PROG[j][26:24]) == f && got_wr[j] < 0 && got_st[j] >= 0) begin
                hit = 1'b1;
                got_wr[j] = e - 1;
                chk(wr_reg == PROG[j][38:35], "R9 written register",
                    int'(wr_reg), int'(PROG[j][38:35]));
              end
            end
          end
        end
      end
      // R10: snapshot after edge 16 of the main sequence
      if (s0 == 0 && e == 17) begin
        chk(dbg_stage == {2'd1, 2'd3, 2'd0, 2'd3, 2'd0}, "R10 stage codes",
            int'(dbg_stage), int'({2'd1, 2'd3, 2'd0, 2'd3, 2'd0}));
        chk(dbg_tag[19:16] == 4'd4 && dbg_tag[15:12] == 4'd5 && dbg_tag[7:4] == 4'd2,
            "R10 order tags", int'(dbg_tag), 16'h45_02);
      end
      if (idx < n) begin
        in_valid = 1'b1;
        in_op    = PROG[s0+idx][40:39];
        in_dst   = PROG[s0+idx][38:35];
        in_src1  = PROG[s0+idx][34:31];
        in_src2  = PROG[s0+idx][30:27];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (in_valid && !issue_stall) begin
        got_iss[s0+idx] = e;
        idx++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int j = s0; j < s0 + n; j++) begin
      chk(got_iss[j] == int'(PROG[j][23:16]), "R1 R2 R3 R8 issue edge",
          got_iss[j], int'(PROG[j][23:16]));
      chk(got_st[j] == int'(PROG[j][15:8]), "R4 R9 start edge",
          got_st[j], int'(PROG[j][15:8]));
      chk(got_wr[j] == int'(PROG[j][7:0]), "R5 R6 R7 write edge",
          got_wr[j], int'(PROG[j][7:0]));
    end
  endtask

  initial begin
    // table walk: three segments with a reset before each
    run_seg(0, 6);
    run_seg(6, 4);
    run_seg(10, 2);
    // directed: reset taken in the middle of activity clears every unit (R11)
    rst = 1'b0;
    in_valid = 1'b1; in_op = 2'd3; in_dst = 4'd9; in_src1 = 4'd1; in_src2 = 4'd1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(dbg_stage[9:8] == 2'd2, "R5 divider executing", int'(dbg_stage[9:8]), 2);
    rst = 1'b1;
    @(negedge clk);
    chk(dbg_stage == '0 && wr_grant == '0, "R11 reset mid-run", int'(dbg_stage), 0);
    rst = 1'b0;
    // directed: the freed divider accepts at once, a second one stalls (R1)
    in_valid = 1'b1; in_op = 2'd3; in_dst = 4'd9;
    #1;
    chk(issue_stall == 1'b0, "R1 idle divider accepts", int'(issue_stall), 0);
    @(negedge clk);
    in_dst = 4'd11;
    #1;
    chk(issue_stall == 1'b1, "R1 busy divider stalls", int'(issue_stall), 1);
    in_valid = 1'b0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule